// File: doc/BRIEF.md
# Programmable Per-Channel Input Debouncer

This block filters a bank of raw input lines before they reach interrupt logic. Each line is first brought into the clock domain by a two-stage synchronizer. It then passes through a filter that lets a new level through only after that level has held for a programmable window. The window length is counted in pulses of a slow tick input.

Software configures the bank through 32-bit control words. Each word covers four channels, and each channel owns one byte of it. A channel byte holds an enable bit, a self-clearing counter-reset bit and a 3-bit window select. Every control word can be reached through three views: a plain view that writes the word as given, a set view that ORs bits in, and a clear view that removes bits. Debounce takes effect only on a line that the surrounding logic reports as level-sensitive. A line without debounce passes its synchronized input straight through.

Top module: `dbnc_bank`

## Requirements
- R1: Channel n lives in the control word at byte address REG_BASE + 4·(n/4), in the byte starting at bit 8·(n mod 4). In that byte, bit 0 is enable and bits 6:4 are the window select. Bits 1, 2, 3 and 7 always read back as 0.
- R2: The set view (REG_BASE + SET_OFS) ORs the written enable and select bits into the stored fields. The clear view (REG_BASE + CLR_OFS) clears every stored bit that is written as 1, so writing 0xFF to a byte through the clear view leaves that channel with enable 0 and select 0.
- R3: Writing bit 1 of a channel byte as 1 through the plain view or the set view zeroes that channel's window counter. The bit is not stored and reads back as 0. Writing it through the clear view has no effect.
- R4: After a counter reset, an enabled channel ignores ticks for SETTLE (default 3) clock cycles following the cycle in which the reset is applied, and its output holds during that time.
- R5: Select codes 0 to 6 give windows of 1, 2, 32, 64, 128, 256 and 512 ticks (0.5 ms to 256 ms at 500 µs per tick). Code 7 gives the same window as code 6.
- R6: An enabled channel's output changes only on a clock edge where tick is high. It takes the synchronized input's value at the tick that completes the window, counting only ticks during which the synchronized input differs from the output.
- R7: Whenever the synchronized input equals the output, the count restarts from zero, so a pulse shorter than the window never reaches the output.
- R8: A channel whose debounce is not in effect drives its output from the raw input through three registers: the output shows a raw change at the third rising clock edge after the change.
- R9: A write of the enable bit is stored only if the channel's level-sensitive input is high at the time of the write. A stored enable takes effect only while that input stays high.
- R10: After reset all stored fields, all outputs and the read data are 0.
- R11: Read data appears one clock after the read address is presented. An address outside the plain view's range reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Write byte address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | ADDR_W | Read byte address |
| reg_rdata | output | 32 | Registered read data (plain view) |
| tick | input | 1 | Slow time-base pulse, one count per high cycle |
| lvl_sens | input | NUM_CH | Line is configured level-sensitive |
| raw_in | input | NUM_CH | Unsynchronized input lines |
| filt_out | output | NUM_CH | Filtered outputs |

## Verification
The assertions rely on two properties of the inputs. First, tick and the register port must be synchronous to clk. Second, a filtered output may move without tick only on a channel whose debounce is off. The raw lines are the only asynchronous inputs, and the stimulus still drives them, the tick and all register writes just after the falling edge, so every value is settled before the next rising edge. Expected output changes are derived from the synchronizer depth and the window tables and are sampled at the falling edge that follows the rising edge on which they are due.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  typedef enum logic [1:0] {
    VIEW_NONE  = 2'd0,
    VIEW_PLAIN = 2'd1,
    VIEW_SET   = 2'd2,
    VIEW_CLR   = 2'd3
  } view_e;

  // positions inside a channel byte
  localparam int EN_POS  = 0;
  localparam int RST_POS = 1;
  localparam int SEL_LSB = 4;
  localparam int SEL_W   = 3;

  // longest window in microseconds
  localparam int unsigned LONGEST_US = 256000;

  // window time for a select code; code 7 aliases code 6
  function automatic int unsigned win_time_us(logic [SEL_W-1:0] code);
    int unsigned us;
    case (code)
      3'd0:    us = 500;
      3'd1:    us = 1000;
      3'd2:    us = 16000;
      3'd3:    us = 32000;
      3'd4:    us = 64000;
      3'd5:    us = 128000;
      default: us = LONGEST_US;
    endcase
    return us;
  endfunction

  // window length in ticks, never below one tick
  function automatic int unsigned win_ticks(logic [SEL_W-1:0] code, int unsigned tick_us);
    int unsigned w;
    w = win_time_us(code) / tick_us;
    return (w == 0) ? 1 : w;
  endfunction

endpackage

// File: rtl/dbnc_regs.sv
module dbnc_regs
  import dbnc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_BASE = 'h500,
  parameter logic [ADDR_W-1:0] SET_OFS  = 'h100,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 'h200
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [31:0]                   wdata,
  input  logic [ADDR_W-1:0]             raddr,
  input  logic [NUM_CH-1:0]             lvl_sens,
  output logic [31:0]                   rdata,
  output logic [NUM_CH-1:0]             cfg_en,
  output logic [NUM_CH-1:0][SEL_W-1:0]  cfg_sel,
  output logic [NUM_CH-1:0]             chan_rst,
  output view_e                         wr_view
);

  localparam int WORDS = (NUM_CH + 3) / 4;
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] SPAN     = ADDR_W'(4 * WORDS);
  localparam logic [ADDR_W-1:0] SET_BASE = REG_BASE + SET_OFS;
  localparam logic [ADDR_W-1:0] CLR_BASE = REG_BASE + CLR_OFS;

  logic [ADDR_W-1:0] off_p, off_s, off_c, off_r;
  logic [IDX_W-1:0]  widx, ridx;
  logic              rhit;
  logic [31:0]       rword;

  // write decode: which view and which word
  always_comb begin
    off_p   = waddr - REG_BASE;
    off_s   = waddr - SET_BASE;
    off_c   = waddr - CLR_BASE;
    wr_view = VIEW_NONE;
    widx    = '0;
    if (we) begin
      if (off_p < SPAN) begin
        wr_view = VIEW_PLAIN;
        widx    = off_p[ADDR_W-1:2];
      end else if (off_s < SPAN) begin
        wr_view = VIEW_SET;
        widx    = off_s[ADDR_W-1:2];
      end else if (off_c < SPAN) begin
        wr_view = VIEW_CLR;
        widx    = off_c[ADDR_W-1:2];
      end
    end
  end

  // per-channel fields
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int LSB = 8 * (n % 4);
    localparam logic [IDX_W-1:0] WIDX = IDX_W'(n / 4);

    logic [7:0] wb;
    logic       hit;
    logic       en_in;
    assign wb    = wdata[LSB +: 8];
    assign hit   = (wr_view != VIEW_NONE) && (widx == WIDX);
    assign en_in = wb[EN_POS] & lvl_sens[n];

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_en[n]   <= 1'b0;
        cfg_sel[n]  <= '0;
        chan_rst[n] <= 1'b0;
      end else begin
        chan_rst[n] <= 1'b0;
        if (hit) begin
          case (wr_view)
            VIEW_PLAIN: begin
              cfg_en[n]   <= en_in;
              cfg_sel[n]  <= wb[SEL_LSB +: SEL_W];
              chan_rst[n] <= wb[RST_POS];
            end
            VIEW_SET: begin
              cfg_en[n]   <= cfg_en[n] | en_in;
              cfg_sel[n]  <= cfg_sel[n] | wb[SEL_LSB +: SEL_W];
              chan_rst[n] <= wb[RST_POS];
            end
            VIEW_CLR: begin
              cfg_en[n]   <= cfg_en[n] & ~wb[EN_POS];
              cfg_sel[n]  <= cfg_sel[n] & ~wb[SEL_LSB +: SEL_W];
            end
            default: ;
          endcase
        end
      end
    end
  end

  // read path: plain view only, registered
  always_comb begin
    off_r = raddr - REG_BASE;
    rhit  = off_r < SPAN;
    ridx  = off_r[ADDR_W-1:2];
    rword = '0;
    if (rhit) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (ridx == IDX_W'(n / 4)) begin
          rword[8*(n%4) +: 8] = {1'b0, cfg_sel[n], 3'b000, cfg_en[n]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rword;
  end

endmodule

// File: rtl/dbnc_chan.sv
module dbnc_chan
  import dbnc_pkg::*;
#(
  parameter int unsigned TICK_US = 500,
  parameter int unsigned SETTLE  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw,
  input  logic             tick,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             cnt_rst,
  output logic             filt
);

  localparam int unsigned MAX_TICKS = win_ticks(3'd7, TICK_US);
  localparam int CNT_W = $clog2(MAX_TICKS + 1);
  localparam int SET_W = $clog2(SETTLE + 1);

  logic             s1, s2;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] win;
  logic [CNT_W:0]   nxt;
  logic [SET_W-1:0] settle;

  assign win = CNT_W'(win_ticks(sel, TICK_US));
  assign nxt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      filt   <= 1'b0;
      cnt    <= '0;
      settle <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (!en) begin
        filt   <= s2;
        cnt    <= '0;
        settle <= '0;
      end else if (cnt_rst) begin
        cnt    <= '0;
        settle <= SET_W'(SETTLE);
      end else if (settle != '0) begin
        cnt    <= '0;
        settle <= settle - 1'b1;
      end else if (s2 == filt) begin
        cnt <= '0;
      end else if (tick) begin
        if (nxt >= {1'b0, win}) begin
          filt <= s2;
          cnt  <= '0;
        end else begin
          cnt <= nxt[CNT_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/dbnc_bank.sv
module dbnc_bank
  import dbnc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_BASE = 'h500,
  parameter logic [ADDR_W-1:0] SET_OFS  = 'h100,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 'h200,
  parameter int unsigned TICK_US = 500,
  parameter int unsigned SETTLE  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [31:0]       reg_rdata,
  input  logic              tick,
  input  logic [NUM_CH-1:0] lvl_sens,
  input  logic [NUM_CH-1:0] raw_in,
  output logic [NUM_CH-1:0] filt_out
);

  logic [NUM_CH-1:0]            cfg_en;
  logic [NUM_CH-1:0][SEL_W-1:0] cfg_sel;
  logic [NUM_CH-1:0]            chan_rst;
  logic [NUM_CH-1:0]            en_eff;
  view_e                        wr_view;

  dbnc_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
    .REG_BASE(REG_BASE), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
  ) u_regs (
    .clk(clk), .rst(rst),
    .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .lvl_sens(lvl_sens), .rdata(reg_rdata),
    .cfg_en(cfg_en), .cfg_sel(cfg_sel), .chan_rst(chan_rst),
    .wr_view(wr_view)
  );

  assign en_eff = cfg_en & lvl_sens;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    dbnc_chan #(.TICK_US(TICK_US), .SETTLE(SETTLE)) u_chan (
      .clk(clk), .rst(rst),
      .raw(raw_in[n]), .tick(tick),
      .en(en_eff[n]), .sel(cfg_sel[n]), .cnt_rst(chan_rst[n]),
      .filt(filt_out[n])
    );
  end

endmodule

// File: rtl/dbnc_bank_chk.sv
module dbnc_bank_chk
  import dbnc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_BASE = 'h500
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [NUM_CH-1:0] lvl_sens,
  input logic [NUM_CH-1:0] filt_out,
  input logic [NUM_CH-1:0] en_eff,
  input logic [NUM_CH-1:0] cfg_en,
  input logic [NUM_CH-1:0] chan_rst,
  input view_e             wr_view,
  input logic [ADDR_W-1:0] reg_raddr,
  input logic [31:0]       reg_rdata
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * ((NUM_CH + 3) / 4));

  logic [ADDR_W-1:0] roff;
  logic              rin;
  assign roff = reg_raddr - REG_BASE;
  assign rin  = roff < SPAN;

  // R11: an address outside the plain range returns zero one clock later
  p_rd_outside_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rin) |-> (reg_rdata == 32'h0));

  // R3: a clear-view write never resets a counter
  p_clear_no_reset_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_view == VIEW_CLR) |=> (chan_rst == '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_p
    // R6: an enabled channel moves only on a tick
    p_tick_gated_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(en_eff[n]) && (filt_out[n] != $past(filt_out[n]))) |-> $past(tick));

    // R4: output holds in the cycle a counter reset is applied
    p_reset_hold_r4: assert property (@(posedge clk) disable iff (rst)
      ($past(chan_rst[n]) && $past(en_eff[n])) |-> $stable(filt_out[n]));

    // R9: a stored enable only appears while the line is level-sensitive
    p_enable_level_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(cfg_en[n]) |-> $past(lvl_sens[n]));
  end

endmodule

bind dbnc_bank dbnc_bank_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .REG_BASE(REG_BASE)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .lvl_sens(lvl_sens),
  .filt_out(filt_out), .en_eff(en_eff), .cfg_en(cfg_en),
  .chan_rst(chan_rst), .wr_view(wr_view),
  .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
);

// File: tb/sim_dbnc_bank.sv
module sim_dbnc_bank;

  localparam int NUM_CH = 8;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_waddr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [ADDR_W-1:0] reg_raddr = '0;
  logic [31:0]       reg_rdata;
  logic              tick = 1'b0;
  logic [NUM_CH-1:0] lvl_sens = '1;
  logic [NUM_CH-1:0] raw_in = '0;
  logic [NUM_CH-1:0] filt_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dbnc_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .tick(tick), .lvl_sens(lvl_sens), .raw_in(raw_in), .filt_out(filt_out)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(string req, logic [ADDR_W-1:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_raddr = a;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 filt", 32'(filt_out), 32'h0);
    rd_check("R10 word0", 12'h500, 32'h0);
    rd_check("R10 word1", 12'h504, 32'h0);
  endtask

  task automatic t_layout();
    wr(12'h500, 32'hFF312211);
    rd_check("R1 layout", 12'h500, 32'h71312011);
    wr(12'h600, 32'h00000040);
    rd_check("R2 set view", 12'h500, 32'h71312051);
    wr(12'h700, 32'hFF000000);
    rd_check("R2 clear wipe", 12'h500, 32'h00312051);
    wr(12'h504, 32'h00000001);
    rd_check("R1 word1", 12'h504, 32'h00000001);
    rd_check("R1 word0 intact", 12'h500, 32'h00312051);
    rd_check("R11 set alias reads 0", 12'h600, 32'h0);
    rd_check("R11 past range", 12'h508, 32'h0);
    wr(12'h700, 32'hFFFFFFFF);
    wr(12'h704, 32'hFFFFFFFF);
    rd_check("R2 all cleared", 12'h500, 32'h0);
  endtask

  task automatic t_disabled();
    @(negedge clk);
    raw_in[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R8 two edges", 32'(filt_out[5]), 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R8 third edge", 32'(filt_out[5]), 32'h1);
  endtask

  task automatic t_level_gate();
    @(negedge clk);
    lvl_sens[6] = 1'b0;
    wr(12'h504, 32'h00010000);
    rd_check("R9 enable refused", 12'h504, 32'h0);
    wr(12'h504, 32'h71000000);
    rd_check("R9 enable stored", 12'h504, 32'h71000000);
    @(negedge clk);
    lvl_sens[7] = 1'b0;
    raw_in[7]   = 1'b1;
    idle(3);
    check("R9 gated enable passes through", 32'(filt_out[7]), 32'h1);
  endtask

  task automatic t_window();
    wr(12'h500, 32'h00000021);
    @(negedge clk); raw_in[0] = 1'b1;
    idle(4);
    check("R6 no tick no change", 32'(filt_out[0]), 32'h0);
    ticks(31);
    check("R5 code2 at 31", 32'(filt_out[0]), 32'h0);
    ticks(1);
    check("R5 code2 at 32", 32'(filt_out[0]), 32'h1);
    wr(12'h500, 32'h00000071);
    @(negedge clk); raw_in[0] = 1'b0;
    idle(3);
    ticks(511);
    check("R5 code7 at 511", 32'(filt_out[0]), 32'h1);
    ticks(1);
    check("R5 code7 at 512", 32'(filt_out[0]), 32'h0);
    wr(12'h500, 32'h00000001);
    @(negedge clk); raw_in[0] = 1'b1;
    idle(3);
    ticks(1);
    check("R5 code0 one tick", 32'(filt_out[0]), 32'h1);
  endtask

  task automatic t_glitch();
    wr(12'h500, 32'h00000011);
    @(negedge clk); raw_in[0] = 1'b0;
    idle(3);
    ticks(1);
    @(negedge clk); raw_in[0] = 1'b1;
    idle(3);
    @(negedge clk); raw_in[0] = 1'b0;
    idle(3);
    ticks(1);
    check("R7 count restarted", 32'(filt_out[0]), 32'h1);
    ticks(1);
    check("R7 full window", 32'(filt_out[0]), 32'h0);
  endtask

  task automatic t_cnt_reset();
    @(negedge clk); raw_in[0] = 1'b1;
    idle(3);
    ticks(1);
    wr(12'h600, 32'h00000002);
    rd_check("R3 reset bit reads 0", 12'h500, 32'h00000011);
    idle(5);
    ticks(1);
    check("R3 counter zeroed", 32'(filt_out[0]), 32'h0);
    ticks(1);
    check("R3 counts again", 32'(filt_out[0]), 32'h1);
  endtask

  task automatic t_settle();
    wr(12'h500, 32'h00000001);
    @(negedge clk); raw_in[0] = 1'b0;
    idle(3);
    wr(12'h600, 32'h00000002);
    tick = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    check("R4 ticks ignored while settling", 32'(filt_out[0]), 32'h1);
    ticks(1);
    check("R4 counting after settle", 32'(filt_out[0]), 32'h0);
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_layout();
    t_disabled();
    t_level_gate();
    t_window();
    t_glitch();
    t_cnt_reset();
    t_settle();
    idle(2);
    summary();
  end

endmodule